// File: doc/BRIEF.md
# Sample Directory Lookup Sequencer

This block is the control sequencer of a standalone speech playback engine. A host places a sample number on an 8-bit port and raises the start pin. The sequencer then reads a small directory at the bottom of the sample ROM to turn that number into the byte address where the sample's data begins. It hands that address to the downstream block interpreter and stays busy until the interpreter reports that playback has finished.

The directory holds five header bytes followed by one two-byte entry per sample. Byte 0 is the index of the highest sample stored in the ROM. Bytes 1 to 4 are a fixed signature that the sequencer never inspects. The entry for sample n sits at bytes 2n+5 (high) and 2n+6 (low). Each entry is a big-endian word address, and the sequencer converts it to a byte address and adds one to step past a leading byte.

All timing runs on a chip tick, which is one input clock in every four. Every directory read happens at a fixed number of ticks after the previous one, including one read whose data is thrown away. A request for a sample number above the stored highest index ends the sequence early and returns the block to idle without a handoff.

Top module: `sample_dir_seq`

## Requirements
- R1: The chip tick is one clock in every four. Every interval below is counted in ticks, so the total time `drq` is high during a full lookup is exactly 4 x (44+28+32+44) = 592 clocks, and 4 x 44 = 176 clocks for an aborted one.
- R2: A rising edge of `start` is accepted only while the block is idle and `rst_n` is high, and accepting it captures `sample_num`. An edge seen while busy, or while `rst_n` is low, has no effect.
- R3: While `rst_n` is low, the block returns to idle within one clock with `busy`, `drq`, `play_go`, `rom_addr` and `play_addr` all zero. This holds even in the middle of a lookup.
- R4: `busy` is high in every cycle in which the block is not idle.
- R5: 70 ticks after a start is accepted, the block presents address 0 with `drq` high. It captures `rom_data` as the highest stored index 44 ticks later. The handoff pulse follows the accepting clock by 1013 to 1016 clocks.
- R6: If the requested number is greater than the captured highest index, the block goes idle with no handoff. A request equal to that index proceeds.
- R7: After byte 0, the reads are presented in this order with `drq` high: address 1 (discarded) for 28 ticks, address 2n+5 for 32 ticks, then address 2n+6 for 44 ticks. `rom_addr` is 0 whenever `drq` is low.
- R8: The handoff address is ((high << 9) | (low << 1)) + 1, where high is the byte read at 2n+5 and low is the byte read at 2n+6.
- R9: 36 ticks after the low byte is captured, `play_go` is high for exactly one clock with `play_addr` valid and `drq` low. `busy` then stays high until `play_done` is seen.
- R10: `play_done` is ignored outside the playback wait. The signature bytes 1 to 4 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the chip tick is derived from it |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| start | input | 1 | A rising edge requests playback |
| sample_num | input | 8 | Requested sample number |
| rom_data | input | 8 | Byte read at `rom_addr` (combinational ROM) |
| rom_addr | output | 17 | Directory byte address being read |
| drq | output | 1 | High while a directory read is pending |
| busy | output | 1 | High whenever the sequencer is not idle |
| play_go | output | 1 | One-clock handoff pulse to the block interpreter |
| play_addr | output | 17 | Sample start byte address, valid from `play_go` on |
| play_done | input | 1 | The interpreter reports the end of playback |

## Verification
A behavioural model in the bench tracks ticks, phases and directory contents with plain integers, and its outputs are compared against the design every clock. The lookup is tried with several directory entries: a small address, a mid-range address, an all-ones entry that produces the largest address, and an entry with only the top bit set. Together these separate a shift or an omitted plus-one from a byte-order mistake. Requests below, equal to and one above the highest stored index separate a correct abort compare from one that is off by one. A start pulse given while busy, a start pulse given during reset, a reset in the middle of a lookup, a stray `play_done`, and zeroed signature bytes each show whether the block ignores stimulus it must not act on.

// File: rtl/sds_pkg.sv
package sds_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GO,
    ST_GET_LAST,
    ST_GET_SKIP,
    ST_GET_HI,
    ST_GET_LO,
    ST_SETTLE,
    ST_PLAY
  } sds_state_e;

  // Byte address of one half of a directory entry (lsb=0 high byte, 1 low byte)
  function automatic logic [31:0] dir_word_addr(input logic [BYTE_W-1:0] idx,
                                                input logic lsb);
    return (32'(idx) << 1) + 32'd5 + 32'(lsb);
  endfunction

  // Big-endian word address converted to a byte address, plus one
  function automatic logic [31:0] start_from_dir(input logic [BYTE_W-1:0] hi,
                                                 input logic [BYTE_W-1:0] lo);
    return ((32'(hi) << 9) | (32'(lo) << 1)) + 32'd1;
  endfunction

endpackage

// File: rtl/sds_clkdiv.sv
module sds_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ce
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign ce = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (ce) cnt <= '0;
    else         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sds_timer.sv
module sds_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = ce && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (ce && cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sds_dir_regs.sv
module sds_dir_regs
  import sds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_req,
  input  logic [BYTE_W-1:0] req_in,
  input  logic              take_last,
  input  logic              take_hi,
  input  logic              take_lo,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] req,
  output logic [BYTE_W-1:0] last,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= '0;
      last <= '0;
      hi   <= '0;
      lo   <= '0;
    end else begin
      if (take_req)  req  <= req_in;
      if (take_last) last <= data;
      if (take_hi)   hi   <= data;
      if (take_lo)   lo   <= data;
    end
  end
endmodule

// File: rtl/sample_dir_seq.sv
module sample_dir_seq
  import sds_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int ADDR_W   = 17,
  parameter int D_START  = 70,
  parameter int D_HEAD   = 44,
  parameter int D_DUMMY  = 28,
  parameter int D_HI     = 32,
  parameter int D_LO     = 44,
  parameter int D_SETTLE = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] sample_num,
  input  logic [BYTE_W-1:0] rom_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              drq,
  output logic              busy,
  output logic              play_go,
  output logic [ADDR_W-1:0] play_addr,
  input  logic              play_done
);
  localparam int M1    = (D_START > D_HEAD) ? D_START : D_HEAD;
  localparam int M2    = (D_DUMMY > D_HI) ? D_DUMMY : D_HI;
  localparam int M3    = (D_LO > D_SETTLE) ? D_LO : D_SETTLE;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int MAX_D = (M12 > M3) ? M12 : M3;
  localparam int CNT_W = $clog2(MAX_D + 1);

  sds_state_e st, st_n;
  logic start_q, start_rise;
  logic ce, tmr_expire, t_load;
  logic [CNT_W-1:0] t_val;
  logic tk_req, tk_last, tk_hi, tk_lo, go_n;
  logic [BYTE_W-1:0] req_q, last_q, hi_q, lo_q;
  logic fetch_last_done, too_far;

  sds_clkdiv #(.DIV(DIV)) u_div (.clk(clk), .rst_n(rst_n), .ce(ce));

  sds_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ce(ce), .load(t_load),
    .load_val(t_val), .expire(tmr_expire)
  );

  sds_dir_regs u_regs (
    .clk(clk), .rst_n(rst_n), .take_req(tk_req), .req_in(sample_num),
    .take_last(tk_last), .take_hi(tk_hi), .take_lo(tk_lo), .data(rom_data),
    .req(req_q), .last(last_q), .hi(hi_q), .lo(lo_q)
  );

  assign start_rise      = start && !start_q;
  assign fetch_last_done = (st == ST_GET_LAST) && tmr_expire;
  assign too_far         = req_q > rom_data;

  always_comb begin
    st_n    = st;
    t_load  = 1'b0;
    t_val   = '0;
    tk_req  = 1'b0;
    tk_last = 1'b0;
    tk_hi   = 1'b0;
    tk_lo   = 1'b0;
    go_n    = 1'b0;
    case (st)
      ST_IDLE: if (start_rise) begin
        st_n = ST_WAIT_GO; t_load = 1'b1; t_val = CNT_W'(D_START); tk_req = 1'b1;
      end
      ST_WAIT_GO: if (tmr_expire) begin
        st_n = ST_GET_LAST; t_load = 1'b1; t_val = CNT_W'(D_HEAD);
      end
      ST_GET_LAST: if (tmr_expire) begin
        tk_last = 1'b1;
        if (too_far) st_n = ST_IDLE;
        else begin
          st_n = ST_GET_SKIP; t_load = 1'b1; t_val = CNT_W'(D_DUMMY);
        end
      end
      ST_GET_SKIP: if (tmr_expire) begin
        st_n = ST_GET_HI; t_load = 1'b1; t_val = CNT_W'(D_HI);
      end
      ST_GET_HI: if (tmr_expire) begin
        tk_hi = 1'b1; st_n = ST_GET_LO; t_load = 1'b1; t_val = CNT_W'(D_LO);
      end
      ST_GET_LO: if (tmr_expire) begin
        tk_lo = 1'b1; st_n = ST_SETTLE; t_load = 1'b1; t_val = CNT_W'(D_SETTLE);
      end
      ST_SETTLE: if (tmr_expire) begin
        st_n = ST_PLAY; go_n = 1'b1;
      end
      ST_PLAY: if (play_done) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      start_q   <= 1'b0;
      play_go   <= 1'b0;
      play_addr <= '0;
    end else begin
      st      <= st_n;
      start_q <= start;
      play_go <= go_n;
      if (go_n) play_addr <= ADDR_W'(start_from_dir(hi_q, lo_q));
    end
  end

  always_comb begin
    case (st)
      ST_GET_SKIP: rom_addr = ADDR_W'(1);
      ST_GET_HI:   rom_addr = ADDR_W'(dir_word_addr(req_q, 1'b0));
      ST_GET_LO:   rom_addr = ADDR_W'(dir_word_addr(req_q, 1'b1));
      default:     rom_addr = '0;
    endcase
  end

  assign drq  = (st == ST_GET_LAST) || (st == ST_GET_SKIP) ||
                (st == ST_GET_HI)   || (st == ST_GET_LO);
  assign busy = (st != ST_IDLE);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_rise) |=> busy);

  // R4
  drq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> busy);

  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_last_done && too_far) |=> !busy);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !tmr_expire) |=> $stable(rom_addr));

  // R9
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_go |=> !play_go);

  // R9
  go_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_go |-> (busy && !drq));

endmodule

// File: tb/tb_sample_dir_seq.sv
module tb_sample_dir_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  sample_num = 8'd0;
  logic [7:0]  rom_data;
  logic [16:0] rom_addr;
  logic        drq, busy, play_go, play_done = 1'b0;
  logic [16:0] play_addr;

  logic [7:0] mem [0:1023];
  int compared = 0;
  int mismatched = 0;
  int wd = 0;

  always #4 clk = ~clk;

  assign rom_data = mem[rom_addr[9:0]];

  sample_dir_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_num(sample_num),
    .rom_data(rom_data), .rom_addr(rom_addr), .drq(drq), .busy(busy),
    .play_go(play_go), .play_addr(play_addr), .play_done(play_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_div = 0, m_phase = 0, m_left = 0, m_req = 0, m_last = 0;
  int m_hi = 0, m_lo = 0, m_paddr = 0;
  bit m_sq = 0, m_go = 0, m_started = 0;

  always @(posedge clk) begin
    bit tick;
    m_started = 1;
    if (!rst_n) begin
      m_div = 0; m_phase = 0; m_left = 0; m_req = 0; m_last = 0;
      m_hi = 0; m_lo = 0; m_paddr = 0; m_sq = 0; m_go = 0;
    end else begin
      tick = (m_div == 3);
      m_div = (m_div + 1) % 4;
      m_go = 0;
      if (m_phase == 0) begin
        if (start && !m_sq) begin m_req = sample_num; m_phase = 1; m_left = 70; end
      end else if (m_phase == 7) begin
        if (play_done) m_phase = 0;
      end else if (tick) begin
        m_left--;
        if (m_left == 0) begin
          case (m_phase)
            1: begin m_phase = 2; m_left = 44; end
            2: begin
              m_last = mem[0];
              if (m_req > m_last) m_phase = 0;
              else begin m_phase = 3; m_left = 28; end
            end
            3: begin m_phase = 4; m_left = 32; end
            4: begin m_hi = mem[2*m_req+5]; m_phase = 5; m_left = 44; end
            5: begin m_lo = mem[2*m_req+6]; m_phase = 6; m_left = 36; end
            6: begin
              m_phase = 7; m_go = 1;
              m_paddr = (((m_hi * 512) + (m_lo * 2)) + 1) % 131072;
            end
            default: m_phase = 0;
          endcase
        end
      end
      m_sq = start;
    end
  end

  function automatic int m_addr();
    case (m_phase)
      3: return 1;
      4: return 2*m_req+5;
      5: return 2*m_req+6;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (m_started) begin
      check(busy == (m_phase != 0), "R4 busy", busy, m_phase != 0);
      check(drq == (m_phase >= 2 && m_phase <= 5), "R7 drq", drq, m_phase >= 2 && m_phase <= 5);
      check(rom_addr == 17'(m_addr()), "R7 rom_addr", rom_addr, m_addr());
      check(play_go == m_go, "R9 play_go", play_go, m_go);
      check(play_addr == 17'(m_paddr), "R8 play_addr", play_addr, m_paddr);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  int cyc, dq;
  bit got_go;

  task automatic pulse_start(input int n);
    @(negedge clk);
    sample_num = 8'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // after the accepting edge, run until handoff or idle
  task automatic run_lookup(input int n, input bit stray_done);
    pulse_start(n);
    cyc = 1; dq = drq ? 1 : 0; got_go = 0;
    while (!play_go && busy && cyc < 3000) begin
      if (stray_done) play_done = (cyc % 50 == 7);
      @(negedge clk);
      cyc++;
      if (drq) dq++;
    end
    play_done = 1'b0;
    got_go = play_go;
  endtask

  task automatic finish_play();
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R9 busy held until done", busy, 1);
    play_done = 1'b1;
    @(negedge clk);
    play_done = 1'b0;
    check(busy == 1'b0, "R9 idle after done", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[0] = 8'd3;
    mem[1] = 8'h5A; mem[2] = 8'hA5; mem[3] = 8'h69; mem[4] = 8'h55;
    mem[5]  = 8'h00; mem[6]  = 8'h10;
    mem[7]  = 8'h12; mem[8]  = 8'h34;
    mem[9]  = 8'hFF; mem[10] = 8'hFF;
    mem[11] = 8'h80; mem[12] = 8'h01;

    repeat (4) @(negedge clk);
    // R3 reset state
    check(busy == 0 && drq == 0 && play_go == 0, "R3 reset outputs", {busy, drq, play_go}, 0);
    check(rom_addr == 0 && play_addr == 0, "R3 reset addresses", rom_addr | play_addr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 R1 R8 main lookup, sample 1
    run_lookup(1, 0);
    check(got_go, "R5 handoff reached", got_go, 1);
    check(cyc >= 1013 && cyc <= 1016, "R5 start to handoff clocks", cyc, 1014);
    check(dq == 592, "R1 drq clocks full lookup", dq, 592);
    check(play_addr == 17'h02469, "R8 address sample 1", play_addr, 17'h02469);
    finish_play();

    // R10 stray play_done while idle and during lookup
    play_done = 1'b1;
    repeat (3) @(negedge clk);
    play_done = 1'b0;
    check(busy == 0, "R10 done while idle", busy, 0);
    run_lookup(0, 1);
    check(got_go, "R10 lookup survives stray done", got_go, 1);
    check(play_addr == 17'h00021, "R8 address sample 0", play_addr, 17'h00021);
    finish_play();

    // R8 largest entry
    run_lookup(2, 0);
    check(play_addr == 17'h1FFFF, "R8 address all ones", play_addr, 17'h1FFFF);
    finish_play();

    // R6 boundary equal to last index
    run_lookup(3, 0);
    check(got_go, "R6 index equal to last plays", got_go, 1);
    check(play_addr == 17'h10003, "R8 address top bit", play_addr, 17'h10003);
    finish_play();

    // R6 abort
    run_lookup(4, 0);
    check(!got_go && !busy, "R6 index above last aborts", {got_go, busy}, 0);
    check(dq == 176, "R1 drq clocks aborted lookup", dq, 176);

    // R10 signature ignored
    mem[1] = 8'h00; mem[2] = 8'h00; mem[3] = 8'h00; mem[4] = 8'h00;
    run_lookup(1, 0);
    check(got_go && play_addr == 17'h02469, "R10 signature ignored", play_addr, 17'h02469);
    finish_play();

    // R2 start while busy ignored
    pulse_start(1);
    repeat (300) @(negedge clk);
    sample_num = 8'd2; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!play_go && cyc < 3000) begin @(negedge clk); cyc++; end
    check(play_addr == 17'h02469, "R2 start while busy ignored", play_addr, 17'h02469);
    finish_play();

    // R2 start during reset ignored
    rst_n = 1'b0;
    @(negedge clk);
    sample_num = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(busy == 0, "R2 start during reset ignored", busy, 0);

    // R3 reset in the middle of a lookup
    pulse_start(1);
    repeat (600) @(negedge clk);
    check(drq == 1, "R7 mid lookup drq", drq, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 0 && drq == 0 && rom_addr == 0, "R3 reset mid lookup", {busy, drq}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(busy == 0, "R3 stays idle after reset", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule